// File: doc/BRIEF.md
# Single-Level Page Table Refill Walker

This block refills a translation buffer from a single-level page table held in memory. When the buffer misses, it hands the walker a virtual page number and an access type. The walker checks the page number against the table length. It then reads one 32-bit entry from the table base plus four times the page number. It inspects that entry and either returns an updated entry for the buffer to install or reports a fault with a cause code.

On a good refill the walker marks the entry as referenced, and also as dirty for a write access. It stores the updated word back to the same table slot before it reports completion. When paging is switched off, the walker skips the table and answers at once with an identity entry whose frame number equals the page number. Only one miss is handled at a time, and `busy` shows when the walker cannot accept another.

Entry layout: the frame number occupies bits 31..13. The flag bits are dirty (bit 12), referenced (bit 11), writable (bit 10) and valid (bit 9). Bits 8..0 belong to software and are never changed by the walker.

Top module: `pt_refill_walker`

## Requirements
- R1: After reset, `busy`, `mem_req_valid` and `done_valid` are all low.
- R2: With paging on and the page number in range, the walker issues exactly one read (`mem_req_we`=0) at `pt_base + 4*vpn`, using the base and length sampled when the miss was accepted.
- R3: A page number greater than or equal to `pt_len` ends in a fault with `done_cause`=1 and issues no memory request.
- R4: A fetched entry with valid (bit 9) clear ends in a fault with `done_cause`=2, and no write is issued.
- R5: On a successful refill, the returned entry has referenced (bit 11) set, and also dirty (bit 12) set when the miss was a write. This word is written back to the entry's address before `done_valid` rises, and `done_pte` equals the word written.
- R6: The frame number field (bits 31..13), the writable and valid bits, and software bits 8..0 reach `done_pte` and the write-back unchanged.
- R7: A write miss whose entry has writable (bit 10) clear ends in a fault with `done_cause`=3, and no write-back is issued.
- R8: With `paging_en`=0, the walker touches no memory. It raises `done_valid` in the cycle after accepting the miss, with `done_pte` holding frame = vpn zero-extended, writable and valid set, and all other bits zero.
- R9: `busy` is high from the cycle after a miss is accepted through the `done_valid` cycle and low in the next cycle. A `miss_valid` that arrives while busy is ignored and produces no result.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the request's valid, address, write flag and data hold steady.
- R11: `done_valid` is a one-cycle pulse. `done_fault` is high exactly when `done_cause` is nonzero, and a successful refill reports cause 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| paging_en | input | 1 | 1 = translate through the table, 0 = identity bypass |
| miss_valid | input | 1 | Miss request, accepted when not busy |
| miss_vpn | input | VPN_W | Virtual page number that missed |
| miss_write | input | 1 | Miss came from a write access |
| pt_base | input | PA_W | Page table base byte address |
| pt_len | input | VPN_W+1 | Number of entries in the table |
| busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | PA_W | Request byte address |
| mem_req_wdata | output | PA_W | Write data (updated entry) |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | PA_W | Read data (raw entry) |
| done_valid | output | 1 | Walk result pulse |
| done_fault | output | 1 | Walk ended in a fault |
| done_cause | output | 2 | 0 none, 1 out of bounds, 2 not valid, 3 write to read-only |
| done_pte | output | PA_W | Entry for refill (zero on fault) |

## Verification
Misses are driven with read and write access types against entries whose flag combinations differ: valid with read-only permission, valid with write permission, valid bit clear, and write access to a read-only page. This separates the four outcomes and shows that the dirty bit follows the access type. Page numbers just below, at and far above the length show where the bound sits. A bypass miss with a page number beyond the length shows that the bound is not applied when paging is off. Holding the memory ready low, and firing a second miss while busy, shows request stability and that the walker accepts one miss at a time. The memory model's counts of reads and writes confirm which outcomes touch memory.

// File: rtl/pt_refill_pkg.sv
package pt_refill_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CHECK = 3'd1,
        ST_READ  = 3'd2,
        ST_WAIT  = 3'd3,
        ST_WBACK = 3'd4,
        ST_DONE  = 3'd5,
        ST_FAULT = 3'd6
    } walk_state_e;

    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'd0,
        CAUSE_BOUND   = 2'd1,
        CAUSE_INVALID = 2'd2,
        CAUSE_PROTECT = 2'd3
    } fault_cause_e;

endpackage

// File: rtl/pt_entry_addr.sv
// Bounds check against the table length and entry address generation.
module pt_entry_addr #(
    parameter int VPN_W = 11,
    parameter int PA_W  = 32
) (
    input  logic [PA_W-1:0]  tbl_base,
    input  logic [VPN_W:0]   tbl_len,
    input  logic [VPN_W-1:0] vpn,
    output logic             in_range,
    output logic [PA_W-1:0]  entry_addr
);
    localparam int IDX_W = VPN_W + 2;

    logic [IDX_W-1:0] byte_index;

    always_comb begin
        in_range   = ({1'b0, vpn} < tbl_len);
        byte_index = {vpn, 2'b00};
        entry_addr = tbl_base + PA_W'(byte_index);
    end
endmodule

// File: rtl/pt_entry_update.sv
// Entry inspection, status-bit update and identity entry for bypass.
module pt_entry_update #(
    parameter int PTE_W = 32,
    parameter int OFF_W = 13,
    parameter int VPN_W = 11
) (
    input  logic [PTE_W-1:0] raw_entry,
    input  logic             is_write,
    input  logic [VPN_W-1:0] pass_vpn,
    output logic             entry_present,
    output logic             access_allowed,
    output logic [PTE_W-1:0] refilled,
    output logic [PTE_W-1:0] identity
);
    localparam int FRAME_W = PTE_W - OFF_W;
    localparam int D_BIT   = OFF_W - 1;
    localparam int R_BIT   = OFF_W - 2;
    localparam int W_BIT   = OFF_W - 3;
    localparam int V_BIT   = OFF_W - 4;

    always_comb begin
        entry_present  = raw_entry[V_BIT];
        access_allowed = !is_write || raw_entry[W_BIT];

        refilled        = raw_entry;
        refilled[R_BIT] = 1'b1;
        if (is_write) begin
            refilled[D_BIT] = 1'b1;
        end

        identity                     = '0;
        identity[PTE_W-1:OFF_W]      = FRAME_W'(pass_vpn);
        identity[W_BIT]              = 1'b1;
        identity[V_BIT]              = 1'b1;
    end
endmodule

// File: rtl/pt_refill_walker.sv
// Single-level page table refill walker: one miss at a time.
module pt_refill_walker #(
    parameter int VPN_W = 11,
    parameter int OFF_W = 13,
    parameter int PA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              paging_en,
    input  logic              miss_valid,
    input  logic [VPN_W-1:0]  miss_vpn,
    input  logic              miss_write,
    input  logic [PA_W-1:0]   pt_base,
    input  logic [VPN_W:0]    pt_len,
    output logic              busy,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_we,
    output logic [PA_W-1:0]   mem_req_addr,
    output logic [PA_W-1:0]   mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [PA_W-1:0]   mem_rsp_rdata,
    output logic              done_valid,
    output logic              done_fault,
    output logic [1:0]        done_cause,
    output logic [PA_W-1:0]   done_pte
);
    import pt_refill_pkg::*;

    localparam int PTE_W = PA_W;
    localparam int LEN_W = VPN_W + 1;

    typedef struct packed {
        walk_state_e        st;
        logic [VPN_W-1:0]   vpn;
        logic               wr;
        logic [PA_W-1:0]    base;
        logic [LEN_W-1:0]   len;
        logic [PA_W-1:0]    addr;
        logic [PTE_W-1:0]   pte;
        fault_cause_e       cause;
    } walk_regs_t;

    walk_regs_t walk_d, walk_q;

    logic             in_range;
    logic [PA_W-1:0]  entry_addr;
    logic             entry_present;
    logic             access_allowed;
    logic [PTE_W-1:0] refilled;
    logic [PTE_W-1:0] identity;

    pt_entry_addr #(
        .VPN_W (VPN_W),
        .PA_W  (PA_W)
    ) addr_i (
        .tbl_base   (walk_q.base),
        .tbl_len    (walk_q.len),
        .vpn        (walk_q.vpn),
        .in_range   (in_range),
        .entry_addr (entry_addr)
    );

    pt_entry_update #(
        .PTE_W (PTE_W),
        .OFF_W (OFF_W),
        .VPN_W (VPN_W)
    ) upd_i (
        .raw_entry      (mem_rsp_rdata),
        .is_write       (walk_q.wr),
        .pass_vpn       (miss_vpn),
        .entry_present  (entry_present),
        .access_allowed (access_allowed),
        .refilled       (refilled),
        .identity       (identity)
    );

    always_comb begin
        walk_d = walk_q;
        unique case (walk_q.st)
            ST_IDLE: begin
                if (miss_valid) begin
                    walk_d.vpn   = miss_vpn;
                    walk_d.wr    = miss_write;
                    walk_d.base  = pt_base;
                    walk_d.len   = pt_len;
                    walk_d.cause = CAUSE_NONE;
                    if (!paging_en) begin
                        walk_d.pte = identity;
                        walk_d.st  = ST_DONE;
                    end else begin
                        walk_d.st  = ST_CHECK;
                    end
                end
            end
            ST_CHECK: begin
                if (in_range) begin
                    walk_d.addr = entry_addr;
                    walk_d.st   = ST_READ;
                end else begin
                    walk_d.cause = CAUSE_BOUND;
                    walk_d.st    = ST_FAULT;
                end
            end
            ST_READ: begin
                if (mem_req_ready) begin
                    walk_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    if (!entry_present) begin
                        walk_d.cause = CAUSE_INVALID;
                        walk_d.st    = ST_FAULT;
                    end else if (!access_allowed) begin
                        walk_d.cause = CAUSE_PROTECT;
                        walk_d.st    = ST_FAULT;
                    end else begin
                        walk_d.pte = refilled;
                        walk_d.st  = ST_WBACK;
                    end
                end
            end
            ST_WBACK: begin
                if (mem_req_ready) begin
                    walk_d.st = ST_DONE;
                end
            end
            ST_DONE, ST_FAULT: begin
                walk_d.st = ST_IDLE;
            end
            default: begin
                walk_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            walk_q <= '0;
        end else begin
            walk_q <= walk_d;
        end
    end

    always_comb begin
        busy          = (walk_q.st != ST_IDLE);
        mem_req_valid = (walk_q.st == ST_READ) || (walk_q.st == ST_WBACK);
        mem_req_we    = (walk_q.st == ST_WBACK);
        mem_req_addr  = walk_q.addr;
        mem_req_wdata = walk_q.pte;
        done_valid    = (walk_q.st == ST_DONE) || (walk_q.st == ST_FAULT);
        done_fault    = (walk_q.st == ST_FAULT);
        done_cause    = walk_q.cause;
        done_pte      = (walk_q.st == ST_DONE) ? walk_q.pte : '0;
    end
endmodule

// File: rtl/pt_refill_walker_chk.sv
module pt_refill_walker_chk #(
    parameter int OFF_W = 13,
    parameter int PA_W  = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic            mem_req_we,
    input logic [PA_W-1:0] mem_req_addr,
    input logic [PA_W-1:0] mem_req_wdata,
    input logic            done_valid,
    input logic            done_fault,
    input logic [1:0]      done_cause,
    input logic [PA_W-1:0] done_pte
);
    localparam int R_BIT = OFF_W - 2;
    localparam int V_BIT = OFF_W - 4;

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we) && $stable(mem_req_wdata)));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);

    // R11
    fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> (done_fault == (done_cause != 2'd0)));

    // R9
    busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !busy);

    // R9
    req_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid || done_valid) |-> busy);

    // R5
    wback_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_we) |-> mem_req_wdata[R_BIT]);

    // R5
    good_entry_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && !done_fault) |-> done_pte[V_BIT]);
endmodule

bind pt_refill_walker pt_refill_walker_chk #(
    .OFF_W (OFF_W),
    .PA_W  (PA_W)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy          (busy),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_we    (mem_req_we),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .done_valid    (done_valid),
    .done_fault    (done_fault),
    .done_cause    (done_cause),
    .done_pte      (done_pte)
);

// File: tb/pt_refill_walker_tb_top.sv
`timescale 1ns/1ps
module pt_refill_walker_tb_top;
    localparam int VPN_W = 11;
    localparam int OFF_W = 13;
    localparam int PA_W  = 32;
    localparam logic [31:0] BASE = 32'h0000_0100;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              paging_en = 1'b1;
    logic              miss_valid = 1'b0;
    logic [VPN_W-1:0]  miss_vpn = '0;
    logic              miss_write = 1'b0;
    logic [PA_W-1:0]   pt_base = BASE;
    logic [VPN_W:0]    pt_len = 12'd40;
    logic              busy;
    logic              mem_req_valid;
    logic              mem_req_ready = 1'b1;
    logic              mem_req_we;
    logic [PA_W-1:0]   mem_req_addr;
    logic [PA_W-1:0]   mem_req_wdata;
    logic              mem_rsp_valid;
    logic [PA_W-1:0]   mem_rsp_rdata;
    logic              done_valid;
    logic              done_fault;
    logic [1:0]        done_cause;
    logic [PA_W-1:0]   done_pte;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    pt_refill_walker #(.VPN_W(VPN_W), .OFF_W(OFF_W), .PA_W(PA_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .paging_en(paging_en),
        .miss_valid(miss_valid), .miss_vpn(miss_vpn), .miss_write(miss_write),
        .pt_base(pt_base), .pt_len(pt_len), .busy(busy),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata), .done_valid(done_valid),
        .done_fault(done_fault), .done_cause(done_cause), .done_pte(done_pte)
    );

    // Memory model: word array, one-cycle read latency, backdoor load port.
    logic [31:0] mem [0:255];
    logic        ld_en = 1'b0;
    logic [7:0]  ld_idx = '0;
    logic [31:0] ld_data = '0;
    int          rd_cnt = 0;
    int          wr_cnt = 0;
    logic [31:0] last_rd_addr = '0;
    logic [31:0] last_wr_addr = '0;

    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (ld_en) mem[ld_idx] <= ld_data;
        if (mem_req_valid && mem_req_ready) begin
            if (mem_req_we) begin
                mem[mem_req_addr[9:2]] <= mem_req_wdata;
                wr_cnt       <= wr_cnt + 1;
                last_wr_addr <= mem_req_addr;
            end else begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_rdata <= mem[mem_req_addr[9:2]];
                rd_cnt        <= rd_cnt + 1;
                last_rd_addr  <= mem_req_addr;
            end
        end
    end

    function automatic logic [31:0] mk_pte(input logic [18:0] frame, input logic d, input logic r,
                                          input logic w, input logic v, input logic [8:0] sw);
        return {frame, d, r, w, v, sw};
    endfunction

    function automatic logic [7:0] slot(input logic [VPN_W-1:0] vpn);
        logic [31:0] a;
        a = BASE + 32'(vpn) * 4;
        return a[9:2];
    endfunction

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load(input logic [VPN_W-1:0] vpn, input logic [31:0] val);
        @(negedge clk);
        ld_en = 1'b1; ld_idx = slot(vpn); ld_data = val;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // Waits (from the current negedge) for the done pulse; then checks it is one cycle wide.
    task automatic wait_done(output logic [31:0] pte, output logic flt, output logic [1:0] cause,
                             output int lat);
        lat = 0;
        while (!done_valid && lat < 60) begin
            @(negedge clk);
            lat++;
        end
        pte = done_pte; flt = done_fault; cause = done_cause;
        check(done_valid, "R11 done arrives", 32'(done_valid), 32'd1);
        @(negedge clk);
        check(!done_valid, "R11 done one-cycle pulse", 32'(done_valid), 32'd0);
        check(!busy, "R9 busy low after done", 32'(busy), 32'd0);
    endtask

    task automatic issue(input logic [VPN_W-1:0] vpn, input logic wr, output logic [31:0] pte,
                         output logic flt, output logic [1:0] cause, output int lat);
        @(negedge clk);
        miss_valid = 1'b1; miss_vpn = vpn; miss_write = wr;
        @(negedge clk);
        miss_valid = 1'b0;
        wait_done(pte, flt, cause, lat);
    endtask

    task automatic t_reset();
        check(!busy, "R1 busy after reset", 32'(busy), 32'd0);
        check(!mem_req_valid, "R1 no request after reset", 32'(mem_req_valid), 32'd0);
        check(!done_valid, "R1 no done after reset", 32'(done_valid), 32'd0);
    endtask

    task automatic t_read_refill();
        logic [31:0] e, pte; logic f; logic [1:0] c; int l, r0, w0;
        e = mk_pte(19'h12345, 1'b0, 1'b0, 1'b0, 1'b1, 9'h1A5);
        load(11'd3, e);
        r0 = rd_cnt; w0 = wr_cnt;
        issue(11'd3, 1'b0, pte, f, c, l);
        check(!f && c == 2'd0, "R11 refill cause none", {30'd0, c}, 32'd0);
        check(pte == (e | 32'h800), "R5 read sets referenced only", pte, e | 32'h800);
        check(pte[31:13] == 19'h12345 && pte[8:0] == 9'h1A5, "R6 frame and software bits kept", pte, e | 32'h800);
        check(rd_cnt == r0 + 1, "R2 one read", 32'(rd_cnt - r0), 32'd1);
        check(last_rd_addr == BASE + 32'd12, "R2 entry address", last_rd_addr, BASE + 32'd12);
        check(wr_cnt == w0 + 1 && last_wr_addr == BASE + 32'd12, "R5 write-back address", last_wr_addr, BASE + 32'd12);
        check(mem[slot(11'd3)] == pte, "R5 written word equals result", mem[slot(11'd3)], pte);
    endtask

    task automatic t_write_refill();
        logic [31:0] e, pte; logic f; logic [1:0] c; int l;
        e = mk_pte(19'h00777, 1'b0, 1'b0, 1'b1, 1'b1, 9'h0F0);
        load(11'd5, e);
        issue(11'd5, 1'b1, pte, f, c, l);
        check(!f, "R5 write refill no fault", 32'(f), 32'd0);
        check(pte == (e | 32'h1800), "R5 write sets dirty and referenced", pte, e | 32'h1800);
        check(mem[slot(11'd5)] == (e | 32'h1800), "R6 write-back word", mem[slot(11'd5)], e | 32'h1800);
    endtask

    task automatic t_invalid();
        logic [31:0] e, pte; logic f; logic [1:0] c; int l, w0;
        e = mk_pte(19'h00ABC, 1'b0, 1'b0, 1'b1, 1'b0, 9'h000);
        load(11'd7, e);
        w0 = wr_cnt;
        issue(11'd7, 1'b0, pte, f, c, l);
        check(f && c == 2'd2, "R4 invalid entry cause", {30'd0, c}, 32'd2);
        check(wr_cnt == w0, "R4 no write-back", 32'(wr_cnt - w0), 32'd0);
        check(mem[slot(11'd7)] == e, "R4 entry untouched", mem[slot(11'd7)], e);
    endtask

    task automatic t_protect();
        logic [31:0] e, pte; logic f; logic [1:0] c; int l, w0;
        e = mk_pte(19'h00321, 1'b0, 1'b0, 1'b0, 1'b1, 9'h011);
        load(11'd9, e);
        w0 = wr_cnt;
        issue(11'd9, 1'b1, pte, f, c, l);
        check(f && c == 2'd3, "R7 read-only write cause", {30'd0, c}, 32'd3);
        check(wr_cnt == w0, "R7 no write-back", 32'(wr_cnt - w0), 32'd0);
    endtask

    task automatic t_bounds();
        logic [31:0] e, pte; logic f; logic [1:0] c; int l, r0;
        e = mk_pte(19'h04040, 1'b0, 1'b0, 1'b1, 1'b1, 9'h000);
        load(11'd39, e);
        issue(11'd39, 1'b0, pte, f, c, l);
        check(!f && pte == (e | 32'h800), "R3 last in-range page refills", pte, e | 32'h800);
        r0 = rd_cnt;
        issue(11'd40, 1'b0, pte, f, c, l);
        check(f && c == 2'd1, "R3 page equal to length faults", {30'd0, c}, 32'd1);
        issue(11'd2000, 1'b1, pte, f, c, l);
        check(f && c == 2'd1, "R3 far page faults", {30'd0, c}, 32'd1);
        check(rd_cnt == r0, "R3 no read on bound fault", 32'(rd_cnt - r0), 32'd0);
    endtask

    task automatic t_bypass();
        logic [31:0] pte; logic f; logic [1:0] c; int l, r0, w0;
        r0 = rd_cnt; w0 = wr_cnt;
        paging_en = 1'b0;
        issue(11'h5AB, 1'b1, pte, f, c, l);
        paging_en = 1'b1;
        check(!f && pte == mk_pte(19'h005AB, 1'b0, 1'b0, 1'b1, 1'b1, 9'h0), "R8 identity entry",
              pte, mk_pte(19'h005AB, 1'b0, 1'b0, 1'b1, 1'b1, 9'h0));
        check(l == 0, "R8 done one cycle after accept", 32'(l), 32'd0);
        check(rd_cnt == r0 && wr_cnt == w0, "R8 no memory access", 32'(rd_cnt - r0 + wr_cnt - w0), 32'd0);
    endtask

    task automatic t_stall();
        logic [31:0] pte, a0; logic f; logic [1:0] c; int l;
        logic stable_ok;
        mem_req_ready = 1'b0;
        @(negedge clk);
        miss_valid = 1'b1; miss_vpn = 11'd3; miss_write = 1'b0;
        @(negedge clk);
        miss_valid = 1'b0;
        @(negedge clk);
        a0 = mem_req_addr;
        stable_ok = mem_req_valid && !mem_req_we;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            stable_ok = stable_ok && mem_req_valid && !mem_req_we && (mem_req_addr == a0);
        end
        check(stable_ok && a0 == BASE + 32'd12, "R10 request held while not ready", a0, BASE + 32'd12);
        mem_req_ready = 1'b1;
        wait_done(pte, f, c, l);
        check(!f && pte[11], "R10 completes after stall", pte, mem[slot(11'd3)]);
    endtask

    task automatic t_busy();
        logic [31:0] e, pte; logic f; logic [1:0] c; int l, r0;
        logic extra;
        e = mk_pte(19'h01111, 1'b0, 1'b0, 1'b1, 1'b1, 9'h003);
        load(11'd11, e);
        load(11'd13, mk_pte(19'h02222, 1'b0, 1'b0, 1'b1, 1'b1, 9'h0));
        r0 = rd_cnt;
        mem_req_ready = 1'b0;
        @(negedge clk);
        miss_valid = 1'b1; miss_vpn = 11'd11; miss_write = 1'b0;
        @(negedge clk);
        check(busy, "R9 busy after accept", 32'(busy), 32'd1);
        miss_vpn = 11'd13;
        repeat (3) @(negedge clk);
        mem_req_ready = 1'b1;
        miss_valid = 1'b0;
        wait_done(pte, f, c, l);
        check(!f && pte == (e | 32'h800), "R9 first miss result kept", pte, e | 32'h800);
        extra = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            extra = extra | done_valid | busy;
        end
        check(!extra, "R9 busy-time miss ignored", 32'(extra), 32'd0);
        check(rd_cnt == r0 + 1, "R9 single read", 32'(rd_cnt - r0), 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_refill();
        t_write_refill();
        t_invalid();
        t_protect();
        t_bounds();
        t_bypass();
        t_stall();
        t_busy();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule